// File: doc/BRIEF.md
# Multicart Program Bank Decoder

This block sits on the CPU side of a multi-game cartridge. It watches CPU writes to the cartridge register window, which spans 0x8000 to 0xFFFF. It keeps the state that decides which 8 KiB program-ROM page appears in each of the four 8 KiB slots of CPU program space. Two of the slots are switchable. A control bit picks which of two slot positions the first switchable bank occupies, and the other positions are fixed to inner pages 14 and 15. On top of that inner layout, a 3-bit outer game-block number moves every page by 16. This is how several games share one ROM. The block also keeps the nametable-mirroring control bit.

Each slot's physical page number is driven out at all times. A CPU program address is also translated combinationally into a physical ROM byte address. The write port is a single-cycle strobe that is always accepted, so it has no ready signal and never applies back-pressure. A register write becomes visible in the cycle after the strobe. Graphics-bank translation, the interrupt counter and the ROM itself belong to other blocks.

Top module: `mcp_prg_decoder`

## Requirements
- R1: After reset the slot pages are 0, 1, 14 and 15 (each taken modulo ROM_PAGES), and `mirror_mode` is 0.
- R2: A write is decoded from `wr_addr` bits 15, 14, 13 and 0 only, so bits 12..1 alias. A write with bit 15 clear changes nothing.
- R3: A bank-data write (key 0x8001) loads switchable bank A when the stored selector (bits 2..0 of the last key 0x8000 write) is 6, and loads bank B when it is 7. Selector values 0 to 5 leave every slot page unchanged.
- R4: With swap bit 6 of the last key 0x8000 write clear, the inner pages of slots 0 to 3 are bank A, bank B, 14 and 15.
- R5: With that swap bit set, the inner pages of slots 0 to 3 are 14, bank B, bank A and 15.
- R6: A write to key 0xA001 stores data bits 2..0 as the outer block, except that the value 7 is stored as 6. Data bits 7..3 are ignored.
- R7: Each slot page equals (outer × 16 + inner page) modulo ROM_PAGES, where ROM_PAGES is a power of two.
- R8: A write to key 0xA000 sets `mirror_mode` to 0 when data bit 0 is 1, and to 1 when data bit 0 is 0. While `four_screen` is high, the write has no effect.
- R9: Writes to keys 0xC000, 0xC001, 0xE000 and 0xE001 change no output of this block.
- R10: `rom_addr` equals the page of the slot chosen by `cpu_addr[14:13]`, concatenated with `cpu_addr[12:0]`, with no register in the path. A register write is seen from the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| four_screen | input | 1 | Cartridge wired for four-screen; mirroring writes are ignored |
| cpu_addr | input | 16 | CPU program-space address to translate |
| slot_page | output | 4×PAGE_W | Physical 8 KiB page for each slot |
| rom_addr | output | PAGE_W+13 | Physical ROM byte address for `cpu_addr` |
| mirror_mode | output | 1 | Nametable mirroring mode |

## Verification
A register write and an address translation can fall in the same cycle. The translation must then return the page that was in force before the write, and the new page must appear from the next cycle. The bench provokes this by holding `cpu_addr` in slot 0 while it rewrites bank A with the swap bit clear. It checks `rom_addr` inside the write cycle against the old arithmetic result and again one cycle later against the new one. The bench also sweeps every outer block value, both layouts and varied bank values through a small ROM size in which the modulo wraps.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

  typedef enum logic [2:0] {
    KEY_NONE,
    KEY_SELECT,
    KEY_BANKDATA,
    KEY_MIRROR,
    KEY_OUTER,
    KEY_OTHER
  } key_e;

  localparam int unsigned FIXED_LO   = 14;
  localparam int unsigned FIXED_HI   = 15;
  localparam int unsigned OUTER_STEP = 4;   // shift: 16 pages per block
  localparam logic [2:0]  OUTER_TOP  = 3'd7;
  localparam logic [2:0]  OUTER_CLMP = 3'd6;
  localparam logic [2:0]  SEL_BANK_A = 3'd6;
  localparam logic [2:0]  SEL_BANK_B = 3'd7;

  // key bits: {a15, a14, a13, a0}
  function automatic key_e decode_key(input logic [3:0] k);
    if (!k[3]) return KEY_NONE;
    case (k[2:0])
      3'b000:  return KEY_SELECT;
      3'b001:  return KEY_BANKDATA;
      3'b010:  return KEY_MIRROR;
      3'b011:  return KEY_OUTER;
      default: return KEY_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/mcp_regs.sv
module mcp_regs
  import mcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_key,
  input  logic [7:0] wr_data,
  input  logic       four_screen,
  output logic       swap_q,
  output logic [7:0] bank_a_q,
  output logic [7:0] bank_b_q,
  output logic [2:0] outer_q,
  output logic       mirror_q
);

  logic [2:0] sel_q;
  key_e       key;

  assign key = decode_key(wr_key);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      swap_q   <= 1'b0;
      bank_a_q <= 8'd0;
      bank_b_q <= 8'd1;
      outer_q  <= '0;
      mirror_q <= 1'b0;
    end else if (wr_en) begin
      case (key)
        KEY_SELECT: begin
          sel_q  <= wr_data[2:0];
          swap_q <= wr_data[6];
        end
        KEY_BANKDATA: begin
          if (sel_q == SEL_BANK_A) bank_a_q <= wr_data;
          if (sel_q == SEL_BANK_B) bank_b_q <= wr_data;
        end
        KEY_MIRROR: begin
          if (!four_screen) mirror_q <= ~wr_data[0];
        end
        KEY_OUTER: begin
          outer_q <= (wr_data[2:0] == OUTER_TOP) ? OUTER_CLMP : wr_data[2:0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mcp_slot_map.sv
module mcp_slot_map
  import mcp_pkg::*;
#(
  parameter int unsigned PAGE_W = 6
) (
  input  logic                   swap,
  input  logic [7:0]             bank_a,
  input  logic [7:0]             bank_b,
  input  logic [2:0]             outer,
  output logic [3:0][PAGE_W-1:0] pages
);

  localparam int unsigned SUM_W = (PAGE_W > 9) ? PAGE_W : 9;

  logic [SUM_W-1:0] base;
  assign base = SUM_W'({outer, {OUTER_STEP{1'b0}}});

  for (genvar s = 0; s < 4; s++) begin : g_slot
    logic [7:0]       inner;
    logic [SUM_W-1:0] sum;
    always_comb begin
      case (s)
        0:       inner = swap ? 8'(FIXED_LO) : bank_a;
        1:       inner = bank_b;
        2:       inner = swap ? bank_a : 8'(FIXED_LO);
        default: inner = 8'(FIXED_HI);
      endcase
      sum = base + SUM_W'(inner);
    end
    assign pages[s] = sum[PAGE_W-1:0];
  end

endmodule

// File: rtl/mcp_addr_xlate.sv
module mcp_addr_xlate #(
  parameter int unsigned PAGE_W = 6
) (
  input  logic [3:0][PAGE_W-1:0] pages,
  input  logic [14:0]            cpu_off,
  output logic [PAGE_W+12:0]     rom_addr
);

  assign rom_addr = {pages[cpu_off[14:13]], cpu_off[12:0]};

endmodule

// File: rtl/mcp_prg_decoder.sv
module mcp_prg_decoder #(
  parameter int unsigned ROM_PAGES = 64,
  localparam int unsigned PAGE_W   = $clog2(ROM_PAGES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [15:0]            wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   four_screen,
  input  logic [15:0]            cpu_addr,
  output logic [3:0][PAGE_W-1:0] slot_page,
  output logic [PAGE_W+12:0]     rom_addr,
  output logic                   mirror_mode
);

  logic       swap_q;
  logic [7:0] bank_a_q;
  logic [7:0] bank_b_q;
  logic [2:0] outer_q;
  logic       unused_addr_bits;

  assign unused_addr_bits = ^{wr_addr[12:1], cpu_addr[15]};

  mcp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_key     ({wr_addr[15:13], wr_addr[0]}),
    .wr_data    (wr_data),
    .four_screen(four_screen),
    .swap_q     (swap_q),
    .bank_a_q   (bank_a_q),
    .bank_b_q   (bank_b_q),
    .outer_q    (outer_q),
    .mirror_q   (mirror_mode)
  );

  mcp_slot_map #(.PAGE_W(PAGE_W)) u_map (
    .swap  (swap_q),
    .bank_a(bank_a_q),
    .bank_b(bank_b_q),
    .outer (outer_q),
    .pages (slot_page)
  );

  mcp_addr_xlate #(.PAGE_W(PAGE_W)) u_xlate (
    .pages   (slot_page),
    .cpu_off (cpu_addr[14:0]),
    .rom_addr(rom_addr)
  );

endmodule

// File: rtl/mcp_prg_decoder_chk.sv
module mcp_prg_decoder_chk #(
  parameter int unsigned PAGE_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [15:0]            wr_addr,
  input logic                   four_screen,
  input logic [15:0]            cpu_addr,
  input logic [3:0][PAGE_W-1:0] slot_page,
  input logic [PAGE_W+12:0]     rom_addr,
  input logic                   mirror_mode,
  input logic [2:0]             outer_q
);

  a_r6_outer_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    outer_q != 3'd7);

  a_r7_last_slot_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    slot_page[3] == PAGE_W'({outer_q, 4'hF}));

  a_r2_low_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[15]) |=> ($stable(slot_page) && $stable(mirror_mode)));

  a_r9_irq_keys_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15] && wr_addr[14]) |=> ($stable(slot_page) && $stable(mirror_mode)));

  a_r8_four_screen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && four_screen) |=> $stable(mirror_mode));

  a_r10_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[12:0] == cpu_addr[12:0]);

endmodule

bind mcp_prg_decoder mcp_prg_decoder_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .four_screen(four_screen),
  .cpu_addr   (cpu_addr),
  .slot_page  (slot_page),
  .rom_addr   (rom_addr),
  .mirror_mode(mirror_mode),
  .outer_q    (outer_q)
);

// File: tb/sim_mcp_prg_decoder.sv
module sim_mcp_prg_decoder;

  localparam int NP = 32;
  localparam int PW = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [15:0]       wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              four_screen = 1'b0;
  logic [15:0]       cpu_addr = 16'h8000;
  logic [3:0][PW-1:0] slot_page;
  logic [PW+12:0]    rom_addr;
  logic              mirror_mode;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  int m_sel = 0, m_swap = 0, m_a = 0, m_b = 1, m_outer = 0, m_mir = 0;

  always #5 clk = ~clk;

  mcp_prg_decoder #(.ROM_PAGES(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .four_screen(four_screen), .cpu_addr(cpu_addr),
    .slot_page(slot_page), .rom_addr(rom_addr), .mirror_mode(mirror_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_page(input int s);
    int inner;
    case (s)
      0:       inner = m_swap ? 14 : m_a;
      1:       inner = m_b;
      2:       inner = m_swap ? m_a : 14;
      default: inner = 15;
    endcase
    return (m_outer * 16 + inner) % NP;
  endfunction

  function automatic void model_write(input int addr, input int data, input bit fs);
    int k;
    if ((addr & 16'h8000) == 0) return;
    k = addr & 16'hE001;
    case (k)
      16'h8000: begin m_sel = data & 7; m_swap = (data >> 6) & 1; end
      16'h8001: begin
        if (m_sel == 6) m_a = data;
        if (m_sel == 7) m_b = data;
      end
      16'hA000: if (!fs) m_mir = (data & 1) ? 0 : 1;
      16'hA001: m_outer = ((data & 7) == 7) ? 6 : (data & 7);
      default: ;
    endcase
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'(addr); wr_data = 8'(data);
    model_write(addr, data, four_screen);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < 4; s++) begin
      check(req, int'(slot_page[s]), exp_page(s));
      cpu_addr = 16'(32'h8000 + s * 32'h2000 + 32'h0155 + s * 7);
      #1;
      check({req, " rom_addr R10"}, int'(rom_addr),
            exp_page(s) * 8192 + int'(cpu_addr[12:0]));
    end
    check({req, " mirror"}, int'(mirror_mode), m_mir);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 slot0", int'(slot_page[0]), 0);
    check("R1 slot1", int'(slot_page[1]), 1);
    check("R1 slot2", int'(slot_page[2]), 14);
    check("R1 slot3", int'(slot_page[3]), 15);
    check("R1 mirror", int'(mirror_mode), 0);

    // R4 R5 R6 R7 sweep
    for (int w = 0; w < 8; w++) begin
      for (int sw = 0; sw < 2; sw++) begin
        wr(16'hA001, 8'hA8 | w);             // R6: upper bits ignored
        wr(16'h8000, 6 | (sw << 6));
        wr(16'h8001, (w * 37 + sw * 11 + 3) & 255);
        wr(16'h8000, 7 | (sw << 6));
        wr(16'h8001, (w * 53 + sw * 29 + 200) & 255);
        check_all(sw ? "R5 R6 R7 swapped" : "R4 R6 R7 normal");
      end
    end

    // R3: selectors 0..5 do not touch program pages
    for (int s = 0; s < 6; s++) begin
      wr(16'h8000, s);
      wr(16'h8001, 8'h5A + s);
      check_all("R3 graphics selector ignored");
    end

    // R2: aliasing and low-address writes
    wr(16'h9FFE, 8'h06);                     // alias of select
    wr(16'h9FFF, 8'h13);                     // alias of bank data
    check_all("R2 alias write");
    wr(16'h7FFF, 8'h40);
    wr(16'h0001, 8'h07);
    wr(16'h6000, 8'hFF);
    check_all("R2 low write ignored");

    // R8 mirroring
    wr(16'hA000, 8'h01); check_all("R8 bit0 set");
    wr(16'hBFFE, 8'hFE); check_all("R8 bit0 clear alias");
    four_screen = 1'b1;
    wr(16'hA000, 8'h01); check_all("R8 four-screen hold");
    four_screen = 1'b0;
    wr(16'hA000, 8'h03); check_all("R8 after four-screen");

    // R9 interrupt-counter keys
    wr(16'hC000, 8'hFF); wr(16'hC001, 8'h07);
    wr(16'hE000, 8'h46); wr(16'hE001, 8'h01);
    wr(16'hFFFE, 8'hFF); wr(16'hDFFF, 8'h47);
    check_all("R9 irq keys ignored");

    // R10 same-cycle write and translation
    wr(16'h8000, 8'h06);
    wr(16'hA001, 8'h02);
    wr(16'h8001, 8'h04);
    @(negedge clk);
    cpu_addr = 16'h8ABC;
    wr_en = 1'b1; wr_addr = 16'h8001; wr_data = 8'h09;
    #1;
    check("R10 old page in write cycle", int'(rom_addr), exp_page(0) * 8192 + 16'h0ABC);
    model_write(16'h8001, 8'h09, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R10 new page after write", int'(rom_addr), exp_page(0) * 8192 + 16'h0ABC);

    // R1 again: reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_sel = 0; m_swap = 0; m_a = 0; m_b = 1; m_outer = 0; m_mir = 0;
    check_all("R1 re-reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule